// File: doc/BRIEF.md
# Shadow-Loaded Memory Configuration Register

This block is a byte-wide configuration register for a nonvolatile memory controller. At reset, its four upper bits are copied from a protected shadow word instead of fixed constants. Normal software can change only the lower control bits. The two most significant bits can be rewritten only while the chip is in its special mode. The two reserved test bits keep the value they received at reset.

The shadow-disable bit also controls a two-byte address window at 0x0FC0/0x0FC1. While that bit is 0, reads and program/erase accesses to the window are steered to the shadow word and the regular array bytes there are hidden. While it is 1, the window reaches the regular array. The steering output is combinational, so a remapped access is routed in the same cycle it is presented.

All interfaces are plain control and status pins. There is no streamed data and no back-pressure. A write happens in any cycle where the strobe is high and the address matches the register.

Top module: `shadow_cfg_reg`

## Requirements
- R1: On a clock edge with `rst_n` low, register bits 7:4 load `shadow_word[7:4]`.
- R2: On reset, bit 3 becomes 1, bit 2 becomes 1, bit 1 becomes 0 and bit 0 becomes 0. Bit 3 reads 1 at all times.
- R3: A write to bits 7:6 takes effect only when `mode_n` is 0. When `mode_n` is 1, those bits keep their value.
- R4: Bits 5:4 ignore every write in both modes and keep their reset-loaded value.
- R5: Bit 2 (wait-stop) and bit 0 (spare) take the write data in either mode.
- R6: Bit 1 (protection lock) is set by writing 1. Once set, it stays 1 until the next reset, whatever data is written.
- R7: A write strobe with an address other than 0x00F0 changes no register bit.
- R8: `shadow_sel` is 1 in the same cycle that `bus_addr` is 0x0FC0 or 0x0FC1 while bit 6 is 0. It is 0 in all other cases.
- R9: `rd_data` always shows the register byte. `dbg_lock_dis` equals bit 7, where 1 means the debug lockout is disabled. `wait_stop` equals bit 2 and `prot_lock` equals bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the shadow bits |
| mode_n | input | 1 | 0 = special mode, in which bits 7:6 are writable |
| shadow_word | input | 16 | Shadow word value; bits 7:4 feed the register at reset |
| bus_addr | input | 16 | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Register contents |
| dbg_lock_dis | output | 1 | Debug lockout disabled when 1 |
| wait_stop | output | 1 | Stop-in-wait flag |
| prot_lock | output | 1 | Sticky protection lock |
| shadow_sel | output | 1 | Steers the window access to the shadow word |

## Verification
A corrupted register bit appears on `rd_data` one cycle after the write or reset that caused it. If the corrupted bit is 7, 2 or 1, it also shows on the matching flag pin in that same cycle. A wrong shadow-disable state shows on `shadow_sel` as soon as the window address is presented, with no added delay. For that reason, steering is checked both before and after the bit changes. The sticky lock and the reserved bits can only be caught after a write that tries to clear or change them, so each such write is followed directly by a readback.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  typedef struct packed {
    logic       dbg_unlock;
    logic       shw_off;
    logic [1:0] tst;
    logic       fixed1;
    logic       wait_stop;
    logic       plock;
    logic       spare;
  } cfg_t;

  localparam int CFG_W = 8;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     REG_ADDR  = 16'h00F0,
  parameter logic [15:0]     WIN_BASE  = 16'h0FC0,
  parameter int              WIN_BYTES = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              reg_hit,
  output logic              win_hit
);
  logic [WIN_BYTES-1:0] byte_hit;

  genvar gi;
  generate
    for (gi = 0; gi < WIN_BYTES; gi++) begin : g_win
      localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(WIN_BASE) + ADDR_W'(gi);
      assign byte_hit[gi] = (addr == BYTE_ADDR);
    end
  endgenerate

  assign reg_hit = (addr == ADDR_W'(REG_ADDR));
  assign win_hit = |byte_hit;
endmodule

// File: rtl/cfg_reg_core.sv
module cfg_reg_core
  import shadow_cfg_pkg::*;
#(
  parameter int NIB_LSB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic [3:0]       shadow_nib,
  output cfg_t             q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q.dbg_unlock <= shadow_nib[3];
      q.shw_off    <= shadow_nib[2];
      q.tst        <= shadow_nib[1:0];
      q.fixed1     <= 1'b1;
      q.wait_stop  <= 1'b1;
      q.plock      <= 1'b0;
      q.spare      <= 1'b0;
    end else if (wr) begin
      if (special) begin
        q.dbg_unlock <= wdata[7];
        q.shw_off    <= wdata[6];
      end
      q.wait_stop <= wdata[2];
      q.plock     <= q.plock | wdata[1];
      q.spare     <= wdata[0];
    end
  end

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> {q.dbg_unlock, q.shw_off, q.tst} == $past(shadow_nib)); // R1

  AST_MODE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($past(wr) && $past(special))) |-> $stable({q.dbg_unlock, q.shw_off})); // R3

  AST_TEST_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(q.tst)); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(q.plock)) |-> q.plock); // R6

  AST_FIXED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q.fixed1); // R2
endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg
  import shadow_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          SHW_W     = 16,
  parameter int          NIB_LSB   = 4,
  parameter logic [15:0] REG_ADDR  = 16'h00F0,
  parameter logic [15:0] WIN_BASE  = 16'h0FC0,
  parameter int          WIN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_n,
  input  logic [SHW_W-1:0]  shadow_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              dbg_lock_dis,
  output logic              wait_stop,
  output logic              prot_lock,
  output logic              shadow_sel
);
  logic reg_hit;
  logic win_hit;
  cfg_t q;

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_dec (
    .addr(bus_addr), .reg_hit(reg_hit), .win_hit(win_hit)
  );

  cfg_reg_core #(.NIB_LSB(NIB_LSB)) u_core (
    .clk(clk), .rst_n(rst_n), .special(!mode_n), .wr(bus_we && reg_hit),
    .wdata(bus_wdata), .shadow_nib(shadow_word[NIB_LSB +: 4]), .q(q)
  );

  assign rd_data      = q;
  assign dbg_lock_dis = q.dbg_unlock;
  assign wait_stop    = q.wait_stop;
  assign prot_lock    = q.plock;
  assign shadow_sel   = win_hit && !q.shw_off;

  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_sel |-> (bus_addr[ADDR_W-1:1] == WIN_BASE[ADDR_W-1:1] && !rd_data[6])); // R8

  AST_OFF_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_addr) != ADDR_W'(REG_ADDR)) |-> $stable(rd_data)); // R7
endmodule

// File: tb/tb_shadow_cfg_reg.sv
module tb_shadow_cfg_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_n = 1;
  logic [15:0] shadow_word = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd_data;
  logic        dbg_lock_dis, wait_stop, prot_lock, shadow_sel;

  shadow_cfg_reg dut (
    .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .shadow_word(shadow_word),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .dbg_lock_dis(dbg_lock_dis), .wait_stop(wait_stop),
    .prot_lock(prot_lock), .shadow_sel(shadow_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] rd;
    logic       sel;
    string      tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [7:0]  model = '0;
  bit          done = 0;

  function automatic logic win_sel(logic [15:0] a, logic [7:0] m);
    return ((a == 16'h0FC0) || (a == 16'h0FC1)) && !m[6];
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.rd  = model;
    e.sel = win_sel(bus_addr, model);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset(logic [15:0] sw, string tag);
    @(posedge clk); #1;
    rst_n = 0; shadow_word = sw; bus_we = 0; bus_addr = 16'h0FC0;
    @(posedge clk); #1;
    rst_n = 1;
    model = {sw[7:4], 4'b1100};
    push(tag);
  endtask

  task automatic op(logic [15:0] a, logic we, logic [7:0] wd, logic mn, string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_we = we; bus_wdata = wd; mode_n = mn;
    @(posedge clk); #1;
    bus_we = 0;
    if (we && a == 16'h00F0) begin
      if (!mn) model[7:6] = wd[7:6];
      model[2] = wd[2];
      model[1] = model[1] | wd[1];
      model[0] = wd[0];
    end
    push(tag);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [4:0] act, want;
      e = sb_q.pop_front();
      n_vec++;
      act  = {rd_data[7], rd_data[2], rd_data[1], shadow_sel, 1'b0};
      want = {e.rd[7], e.rd[2], e.rd[1], e.sel, 1'b0};
      if (rd_data !== e.rd || {dbg_lock_dis, wait_stop, prot_lock, shadow_sel} !== want[4:1]) begin
        n_bad++;
        $display("FAIL %s: rd=%02h flags(dbg,ws,pl,sel)=%b expected rd=%02h flags=%b",
                 e.tag, rd_data, {dbg_lock_dis, wait_stop, prot_lock, shadow_sel}, e.rd, want[4:1]);
      end
      if (act[0] !== 1'b0) n_bad++;
    end
  end

  initial begin
    do_reset(16'h00F0, "R1 R2 reset shadow F, window to array");
    do_reset(16'h0030, "R1 R2 reset shadow 3, window to shadow");
    op(16'h0FC1, 0, 8'h00, 1, "R8 upper window byte steered");
    op(16'h0FC2, 0, 8'h00, 1, "R8 above window");
    op(16'h0FBF, 0, 8'h00, 1, "R8 below window");
    op(16'h00F0, 1, 8'hC5, 1, "R3 R5 R9 normal write, top bits rejected");
    op(16'h00F0, 1, 8'h40, 0, "R3 R4 special write sets shadow-disable");
    op(16'h0FC0, 0, 8'h00, 1, "R8 window to array after disable");
    op(16'h00F0, 1, 8'h00, 0, "R3 special write clears shadow-disable");
    op(16'h0FC1, 0, 8'h00, 1, "R8 window back to shadow");
    op(16'h00F1, 1, 8'hFF, 0, "R7 write to other address ignored");
    op(16'h00F0, 1, 8'h02, 1, "R6 lock set in normal mode");
    op(16'h00F0, 1, 8'h00, 0, "R6 lock survives write of 0");
    op(16'h00F0, 1, 8'hFF, 0, "R9 special write all ones");
    do_reset(16'h0080, "R1 reset shadow 8, lock cleared");
    op(16'h00F0, 1, 8'h30, 0, "R4 reserved bits ignore ones");
    op(16'h00F0, 1, 8'hC0, 1, "R3 normal write of top bits ignored");
    do_reset(16'hFF00, "R1 reset from word with zero nibble");
    @(posedge clk); @(negedge clk); @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule